// File: doc/BRIEF.md
# Single-Line Bus Master with Programmable Slot Timing

This block is the master of a 1-Wire style bus. It drives the shared open-drain line low through `line_pull` and reads the resolved level back on `line_in`. It runs one bus operation per command: a reset with a presence check, a write slot for a 0 or a 1, or a read slot. Every phase length comes from a static configuration input. The length is counted in ticks of the bus timebase, which `tick_en` marks as a clock enable.

Commands use a valid/ready handshake. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low for the whole operation, so a held `cmd_valid` waits and changes nothing. It is taken on the first edge after the operation ends. Results are plain status pins: `done` pulses once per operation, `rd_bit` holds the last bit read, and `presence` holds the result of the last reset.

The read-back path passes through a level filter. In normal mode the filter needs 6 consecutive ticks of a new level before it accepts that level. In bypass mode it needs 3. The read and presence sample offsets must leave room for this latency.

Top module: `owm_master`

## Requirements
- R1: After reset, `busy`, `done`, `line_pull`, `rd_bit` and `presence` are 0 and `cmd_ready` is 1.
- R2: A command is taken only when `cmd_valid` and `cmd_ready` are both high at a clock edge. `cmd_ready` is low while `busy` is high. A command offered during an operation is neither started nor queued.
- R3: A reset command (`cmd_op` = 2'b00) pulls the line for `cfg_rst_lo`+1 ticks and then releases it for `cfg_rst_hi`+1 ticks. `busy` drops after the release phase. `done` is high for exactly the one cycle in which `busy` first reads 0.
- R4: Release ticks are numbered from 0, starting with the first tick after the line is released. At release tick `cfg_pres_samp`, `presence` is loaded with the inverse of the filtered line. A low level there sets the flag.
- R5: A write command (`cmd_op` = 2'b01) with `cmd_bit` = 0 pulls the line for `cfg_low0`+1 ticks. Every slot lasts `cfg_slot`+1 ticks from the edge that takes the command to the edge that ends it.
- R6: A write with `cmd_bit` = 1, and any read (`cmd_op` = 2'b10 or 2'b11), pulls the line for `cfg_low1`+1 ticks. The slot length is the same as in R5.
- R7: In a read slot, slot ticks are numbered from 0 at the command. At slot tick `cfg_low1`+1+`cfg_rd_samp`, `rd_bit` is loaded with the filtered line. `rd_bit` and `presence` do not change between operations.
- R8: The filter moves to a new level only after 6 consecutive ticks of that level on `line_in`, or 3 ticks when `deglitch_bypass` is 1. A shorter excursion has no effect on a sample.
- R9: All phase counters advance only on cycles with `tick_en` high. While `busy` is high and `tick_en` is low, `line_pull` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Bus timebase enable, one tick per high cycle |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken (idle) |
| cmd_op | input | 2 | 00 reset, 01 write, 10/11 read |
| cmd_bit | input | 1 | Bit value for a write |
| cfg_slot | input | TW | Slot length minus one |
| cfg_low0 | input | TW | Pull time for a 0 write, minus one |
| cfg_low1 | input | TW | Pull time for a 1 write or a read, minus one |
| cfg_rst_lo | input | TW | Reset pull time minus one |
| cfg_rst_hi | input | TW | Reset release time minus one |
| cfg_pres_samp | input | TW | Presence sample offset after release |
| cfg_rd_samp | input | TW | Read sample offset after release |
| deglitch_bypass | input | 1 | Selects the short filter latency |
| line_in | input | 1 | Resolved bus level |
| line_pull | output | 1 | 1 pulls the bus low |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| rd_bit | output | 1 | Last bit read |
| presence | output | 1 | Last presence result |

## Verification
The bench uses the default parameters: 10-bit counters, a 6-tick filter and a 3-tick bypassed filter. Timing inputs are set to typical values: a 120-tick slot, 61- and 2-tick pulls, 480-tick reset phases, presence sample at 80 and read sample at 7. With these values a full reset fits in the counter width, and a 5-tick device glitch falls between the two filter latencies. The same glitch is therefore rejected with the filter and accepted in bypass. A short presence pulse that ends before the sample point tests where the presence sample is taken. A half-rate `tick_en` shows that all timing scales with the tick rather than the clock.

// File: rtl/owm_pkg.sv
package owm_pkg;
  localparam logic [1:0] OP_RESET = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RST_LO = 2'd1,
    ST_RST_HI = 2'd2,
    ST_SLOT   = 2'd3
  } owm_state_t;
endpackage

// File: rtl/owm_deglitch.sv
module owm_deglitch #(
  parameter int FULL_LAT = 6,
  parameter int BYP_LAT  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic bypass,
  input  logic raw_in,
  output logic clean_out
);
  localparam int CW = $clog2(FULL_LAT + 1);
  localparam logic [CW-1:0] FULL_LAST = CW'(FULL_LAT - 1);
  localparam logic [CW-1:0] BYP_LAST  = CW'(BYP_LAT - 1);

  logic [CW-1:0] run_q;
  logic [CW-1:0] last;

  assign last = bypass ? BYP_LAST : FULL_LAST;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q     <= '0;
      clean_out <= 1'b1;
    end else if (tick_en) begin
      if (raw_in == clean_out) begin
        run_q <= '0;
      end else if (run_q >= last) begin
        run_q     <= '0;
        clean_out <= raw_in;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/owm_seq.sv
module owm_seq
  import owm_pkg::*;
#(
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic          wr_bit,
  input  logic [TW-1:0] cfg_slot,
  input  logic [TW-1:0] cfg_low0,
  input  logic [TW-1:0] cfg_low1,
  input  logic [TW-1:0] cfg_rst_lo,
  input  logic [TW-1:0] cfg_rst_hi,
  input  logic [TW-1:0] cfg_pres_samp,
  input  logic [TW-1:0] cfg_rd_samp,
  input  logic          line_clean,
  output logic          line_pull,
  output logic          busy,
  output logic          done,
  output logic          rd_bit,
  output logic          presence
);
  localparam int XW = TW + 1;

  owm_state_t    st_q;
  logic [TW-1:0] cnt_q;
  logic          is_rd_q;
  logic          bit_q;
  logic [TW-1:0] low_sel;
  logic [XW-1:0] rd_point;

  assign low_sel  = (is_rd_q || bit_q) ? cfg_low1 : cfg_low0;
  assign rd_point = XW'(cfg_low1) + XW'(cfg_rd_samp) + XW'(1);
  assign busy     = (st_q != ST_IDLE);

  always_comb begin
    unique case (st_q)
      ST_RST_LO: line_pull = 1'b1;
      ST_SLOT:   line_pull = (cnt_q <= low_sel);
      default:   line_pull = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      is_rd_q  <= 1'b0;
      bit_q    <= 1'b0;
      done     <= 1'b0;
      rd_bit   <= 1'b0;
      presence <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            cnt_q   <= '0;
            is_rd_q <= op[1];
            bit_q   <= wr_bit;
            st_q    <= (op == OP_RESET) ? ST_RST_LO : ST_SLOT;
          end
        end
        ST_RST_LO: begin
          if (tick_en) begin
            if (cnt_q == cfg_rst_lo) begin
              cnt_q <= '0;
              st_q  <= ST_RST_HI;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_RST_HI: begin
          if (tick_en) begin
            if (cnt_q == cfg_pres_samp) presence <= ~line_clean;
            if (cnt_q == cfg_rst_hi) begin
              st_q <= ST_IDLE;
              done <= 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_SLOT: begin
          if (tick_en) begin
            if (is_rd_q && (XW'(cnt_q) == rd_point)) rd_bit <= line_clean;
            if (cnt_q == cfg_slot) begin
              st_q <= ST_IDLE;
              done <= 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/owm_master.sv
module owm_master #(
  parameter int TW       = 10,
  parameter int FULL_LAT = 6,
  parameter int BYP_LAT  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic          cmd_bit,
  input  logic [TW-1:0] cfg_slot,
  input  logic [TW-1:0] cfg_low0,
  input  logic [TW-1:0] cfg_low1,
  input  logic [TW-1:0] cfg_rst_lo,
  input  logic [TW-1:0] cfg_rst_hi,
  input  logic [TW-1:0] cfg_pres_samp,
  input  logic [TW-1:0] cfg_rd_samp,
  input  logic          deglitch_bypass,
  input  logic          line_in,
  output logic          line_pull,
  output logic          busy,
  output logic          done,
  output logic          rd_bit,
  output logic          presence
);
  logic line_clean;
  logic accept;

  assign cmd_ready = ~busy;
  assign accept    = cmd_valid & cmd_ready;

  owm_deglitch #(
    .FULL_LAT (FULL_LAT),
    .BYP_LAT  (BYP_LAT)
  ) u_filt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bypass    (deglitch_bypass),
    .raw_in    (line_in),
    .clean_out (line_clean)
  );

  owm_seq #(
    .TW (TW)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_en       (tick_en),
    .start         (accept),
    .op            (cmd_op),
    .wr_bit        (cmd_bit),
    .cfg_slot      (cfg_slot),
    .cfg_low0      (cfg_low0),
    .cfg_low1      (cfg_low1),
    .cfg_rst_lo    (cfg_rst_lo),
    .cfg_rst_hi    (cfg_rst_hi),
    .cfg_pres_samp (cfg_pres_samp),
    .cfg_rd_samp   (cfg_rd_samp),
    .line_clean    (line_clean),
    .line_pull     (line_pull),
    .busy          (busy),
    .done          (done),
    .rd_bit        (rd_bit),
    .presence      (presence)
  );
endmodule

// File: rtl/owm_master_chk.sv
module owm_master_chk (
  input logic clk,
  input logic rst_n,
  input logic tick_en,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic busy,
  input logic done,
  input logic line_pull,
  input logic rd_bit,
  input logic presence
);
  assert_accept_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> busy);

  assert_pull_in_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
    line_pull |-> busy);

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_presence_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_valid) |=> $stable(presence));

  assert_rdbit_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_valid) |=> $stable(rd_bit));

  assert_no_tick_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick_en) |=> ($stable(line_pull) && busy));
endmodule

bind owm_master owm_master_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .busy      (busy),
  .done      (done),
  .line_pull (line_pull),
  .rd_bit    (rd_bit),
  .presence  (presence)
);

// File: tb/owm_master_bench.sv
module owm_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 10;
  localparam int NV = 11;

  localparam int V_OP   [NV] = '{0, 0, 0, 1, 1, 2, 2, 2, 2, 3, 2};
  localparam int V_BIT  [NV] = '{0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0};
  localparam int V_MODE [NV] = '{1, 0, 2, 0, 0, 0, 3, 4, 4, 3, 3};
  localparam int V_BYP  [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1};
  localparam int V_LOW  [NV] = '{480, 480, 480, 61, 2, 2, 2, 2, 2, 2, 2};
  localparam int V_BUSY [NV] = '{960, 960, 960, 120, 120, 120, 120, 120, 120, 120, 120};
  localparam int V_VAL  [NV] = '{1, 0, 0, 0, 0, 1, 0, 1, 0, 0, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_mode = 1'b0;
  logic tick_tog = 1'b0;
  logic tick_en;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_op = 2'b00;
  logic cmd_bit = 1'b0;
  logic deglitch_bypass = 1'b0;
  logic line_in, line_pull, busy, done, rd_bit, presence;
  logic slave_low = 1'b0;
  logic pull_q = 1'b0;
  int mode = 0;
  int k = 1000;
  int j = 2000;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) tick_tog <= ~tick_tog;
  assign tick_en = tick_mode ? tick_tog : 1'b1;
  assign line_in = ~(line_pull | slave_low);

  owm_master #(.TW(TW)) u_owm_master (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_bit(cmd_bit),
    .cfg_slot(10'd119), .cfg_low0(10'd60), .cfg_low1(10'd1),
    .cfg_rst_lo(10'd479), .cfg_rst_hi(10'd479),
    .cfg_pres_samp(10'd80), .cfg_rd_samp(10'd7),
    .deglitch_bypass(deglitch_bypass), .line_in(line_in), .line_pull(line_pull),
    .busy(busy), .done(done), .rd_bit(rd_bit), .presence(presence)
  );

  // device model: k counts cycles from the start of a pull, j from its release
  always @(negedge clk) begin
    if (line_pull && !pull_q) k = 0; else if (k < 1000) k = k + 1;
    if (!line_pull && pull_q) j = 0; else if (j < 2000) j = j + 1;
    pull_q = line_pull;
    case (mode)
      1: slave_low = (j >= 20 && j <= 119);
      2: slave_low = (j >= 20 && j <= 50);
      3: slave_low = (k <= 14);
      4: slave_low = (k >= 4 && k <= 8);
      default: slave_low = 1'b0;
    endcase
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_cmd(input int op, input int b, output int lowc, output int busyc, output int done_ok);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_bit = b[0];
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    lowc = 0; busyc = 0;
    while (busy && busyc < 5000) begin
      if (line_pull) lowc++;
      busyc++;
      @(negedge clk);
    end
    done_ok = done ? 1 : 0;
    @(negedge clk);
    if (done) done_ok = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int lowc, busyc, dok;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 pull", line_pull, 0);
    chk("R1 done", done, 0);
    chk("R1 rd_bit", rd_bit, 0);
    chk("R1 presence", presence, 0);
    chk("R1 ready", cmd_ready, 1);

    for (int v = 0; v < NV; v++) begin
      mode = V_MODE[v];
      deglitch_bypass = V_BYP[v][0];
      repeat (200) @(negedge clk);
      run_cmd(V_OP[v], V_BIT[v], lowc, busyc, dok);
      if (V_OP[v] == 0) begin
        chk("R3 reset pull", lowc, V_LOW[v]);
        chk("R3 reset busy", busyc, V_BUSY[v]);
        chk("R4 presence", presence, V_VAL[v]);
      end else if (V_OP[v] == 1 && V_BIT[v] == 0) begin
        chk("R5 write0 pull", lowc, V_LOW[v]);
        chk("R5 slot length", busyc, V_BUSY[v]);
      end else begin
        chk("R6 short pull", lowc, V_LOW[v]);
        chk("R6 slot length", busyc, V_BUSY[v]);
        if (V_OP[v] >= 2) begin
          if (V_MODE[v] == 4) chk("R8 filtered read", rd_bit, V_VAL[v]);
          else chk("R7 read bit", rd_bit, V_VAL[v]);
        end
      end
      chk("R3 done pulse", dok, 1);
      mode = 0;
    end

    // R7: results hold between operations
    repeat (20) @(negedge clk);
    chk("R7 rd_bit hold", rd_bit, 0);
    chk("R4 presence hold", presence, 0);

    // R2: command offered during an operation is ignored
    deglitch_bypass = 1'b0;
    repeat (50) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b01; cmd_bit = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R2 ready low while busy", cmd_ready, 0);
    cmd_op = 2'b00;
    lowc = 0; busyc = 0;
    while (busy && busyc < 5000) begin
      if (line_pull) lowc++;
      busyc++;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    chk("R2 first command kept pull", lowc, 61);
    chk("R2 first command kept length", busyc, 120);
    busyc = 0;
    repeat (10) begin
      @(negedge clk);
      if (busy || line_pull) busyc++;
    end
    chk("R2 offered command not queued", busyc, 0);

    // R9: half-rate ticks double the timing
    tick_mode = 1'b1;
    repeat (20) @(negedge clk);
    run_cmd(1, 0, lowc, busyc, dok);
    chk("R9 pull at half rate", (lowc == 121 || lowc == 122) ? 1 : 0, 1);
    chk("R9 slot at half rate", (busyc == 239 || busyc == 240) ? 1 : 0, 1);
    tick_mode = 1'b0;

    repeat (10) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule